// File: doc/BRIEF.md
# Move-Triggered Integer Arithmetic Unit

This block is an integer function unit for a processor whose program consists only of data moves. It has no opcode input and no register operands. A move bus carries writes that name a destination socket. Writing the unit's operand socket only stores a value. Writing one of its four trigger sockets starts an operation: the socket chosen selects the operation, the written value is the second operand, and the stored operand is the first.

The result goes through one internal pipeline register and then settles in a result register. It stays there for any number of reads until a later operation overwrites it. Compare operations also drive a single-bit flag that a surrounding datapath can copy into a boolean guard register.

Several move buses can reach the unit in the same cycle. An operand move and a trigger move may therefore arrive together, and the trigger then uses the value that is being written in that cycle. A dyadic operation takes three transports: an operand move, a trigger move and a result move.

The unit never stalls, so the move inputs carry no ready signal and apply no back-pressure. Every valid move that names one of the unit's sockets is consumed in the cycle it is presented. Reading the result is non-destructive and needs no handshake: `res_valid` rises with the first result after reset and stays high.

Top module: `tta_alu_unit`

## Requirements
- R1: A move to the operand socket (id 8) stores the value and starts nothing: the result, flag and `res_valid` do not change because of it.
- R2: A move to a trigger socket starts an operation with the stored operand as first operand A and the moved value as second operand B.
- R3: A trigger accepted at clock edge N updates `res_data` at edge N+1 and not before; `res_valid` becomes 1 at that same edge.
- R4: The trigger socket selects the operation. Socket 12 computes A+B modulo 2^32, socket 13 computes A-B modulo 2^32, socket 14 computes A==B, and socket 15 computes A>B with both operands treated as signed two's complement.
- R5: A compare writes `res_data` as 1 when it holds and 0 when it does not, with every upper bit 0, and sets `res_flag` to the same bit.
- R6: Add and subtract leave `res_flag` unchanged.
- R7: The result register and flag keep their values for as long as no further trigger completes, and `res_valid` never falls once set.
- R8: When an operand move and a trigger move arrive in the same cycle on different buses, the operation uses the newly moved operand.
- R9: Moves whose socket id is neither 8 nor 12 to 15, and cycles with no valid move, change no state of the unit.
- R10: After reset, `res_data` is 0, `res_flag` is 0, `res_valid` is 0 and the stored operand is 0.
- R11: Triggers in consecutive cycles each produce their own result in consecutive cycles, in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mv_valid | input | NUM_BUS (2) | One valid bit per move bus |
| mv_dst | input | NUM_BUS*SOCK_W (8) | Destination socket id of each bus; bus i uses bits [4i+3:4i] |
| mv_data | input | NUM_BUS*DATA_W (64) | Moved value of each bus; bus i uses bits [32i+31:32i] |
| res_data | output | DATA_W (32) | Result register |
| res_flag | output | 1 | Boolean outcome of the most recent compare |
| res_valid | output | 1 | High once any result has been written since reset |

## Verification
The assertions assume that each cycle carries at most one trigger move and at most one operand move across all buses. With two triggers in one cycle, the lowest-numbered bus would win silently. The random stimulus keeps to this rule: it drops the second bus's move whenever it would hit the same kind of socket as the first. The directed stimulus issues one trigger per cycle by design. The flag and boolean-shape properties also rely on the operation code held in the pipeline stage. That code is only ever loaded from a decoded trigger socket.

// File: rtl/tta_fu_pkg.sv
package tta_fu_pkg;
  typedef enum logic [1:0] {
    FU_ADD = 2'd0,
    FU_SUB = 2'd1,
    FU_EQ  = 2'd2,
    FU_GT  = 2'd3
  } fu_op_e;

  function automatic logic fu_is_compare(input fu_op_e op);
    return op[1];
  endfunction
endpackage

// File: rtl/tta_fu_decode.sv
module tta_fu_decode
  import tta_fu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SOCK_W  = 4,
  parameter int NUM_BUS = 2,
  parameter logic [SOCK_W-1:0] OPND_SOCK = 4'd8,
  parameter logic [SOCK_W-1:0] TRIG_BASE = 4'd12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_BUS-1:0]        mv_valid,
  input  logic [NUM_BUS*SOCK_W-1:0] mv_dst,
  input  logic [NUM_BUS*DATA_W-1:0] mv_data,
  output logic                      opnd_we,
  output logic [DATA_W-1:0]         opnd_val,
  output logic                      trig_fire,
  output logic [DATA_W-1:0]         trig_val,
  output fu_op_e                    trig_op
);
  localparam int TRIG_SEL_W = 2;
  localparam int TRIG_HI_W  = SOCK_W - TRIG_SEL_W;

  logic [NUM_BUS-1:0] hit_opnd;
  logic [NUM_BUS-1:0] hit_trig;

  for (genvar gi = 0; gi < NUM_BUS; gi++) begin : g_bus
    logic [SOCK_W-1:0] dst;
    assign dst = mv_dst[gi*SOCK_W +: SOCK_W];
    assign hit_opnd[gi] = mv_valid[gi] && (dst == OPND_SOCK);
    assign hit_trig[gi] = mv_valid[gi] &&
      (dst[SOCK_W-1 -: TRIG_HI_W] == TRIG_BASE[SOCK_W-1 -: TRIG_HI_W]);
  end

  // Lowest-numbered bus wins if a rule is broken; stimulus must avoid that.
  always_comb begin
    opnd_we   = 1'b0;
    opnd_val  = '0;
    trig_fire = 1'b0;
    trig_val  = '0;
    trig_op   = FU_ADD;
    for (int i = NUM_BUS - 1; i >= 0; i--) begin
      if (hit_opnd[i]) begin
        opnd_we  = 1'b1;
        opnd_val = mv_data[i*DATA_W +: DATA_W];
      end
      if (hit_trig[i]) begin
        trig_fire = 1'b1;
        trig_val  = mv_data[i*DATA_W +: DATA_W];
        trig_op   = fu_op_e'(mv_dst[i*SOCK_W +: TRIG_SEL_W]);
      end
    end
  end

  AST_SINGLE_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(hit_trig) <= 1 && $countones(hit_opnd) <= 1) else $error("AST_SINGLE_TRIGGER"); // R2
endmodule

// File: rtl/tta_fu_exec.sv
module tta_fu_exec
  import tta_fu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fu_op_e              op,
  input  logic [DATA_W-1:0]   opa,
  input  logic [DATA_W-1:0]   opb,
  output logic [DATA_W-1:0]   result,
  output logic                is_cmp
);
  logic cmp_bit;

  always_comb begin
    cmp_bit = 1'b0;
    result  = '0;
    unique case (op)
      FU_ADD: result = opa + opb;
      FU_SUB: result = opa - opb;
      FU_EQ: begin
        cmp_bit = (opa == opb);
        result  = {{(DATA_W-1){1'b0}}, cmp_bit};
      end
      FU_GT: begin
        cmp_bit = ($signed(opa) > $signed(opb));
        result  = {{(DATA_W-1){1'b0}}, cmp_bit};
      end
      default: result = '0;
    endcase
  end

  assign is_cmp = fu_is_compare(op);
endmodule

// File: rtl/tta_fu_pipe.sv
module tta_fu_pipe
  import tta_fu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opnd_we,
  input  logic [DATA_W-1:0] opnd_val,
  input  logic              trig_fire,
  input  logic [DATA_W-1:0] trig_val,
  input  fu_op_e            trig_op,
  input  logic [DATA_W-1:0] exec_res,
  input  logic              exec_cmp,
  output logic              stg_vld,
  output fu_op_e            stg_op,
  output logic [DATA_W-1:0] stg_a,
  output logic [DATA_W-1:0] stg_b,
  output logic [DATA_W-1:0] res_data,
  output logic              res_flag,
  output logic              res_valid
);
  logic [DATA_W-1:0] opnd_q;
  logic [DATA_W-1:0] first_opnd;

  // Same-cycle operand move is forwarded to the trigger.
  assign first_opnd = opnd_we ? opnd_val : opnd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opnd_q  <= '0;
      stg_vld <= 1'b0;
      stg_op  <= FU_ADD;
      stg_a   <= '0;
      stg_b   <= '0;
    end else begin
      if (opnd_we) opnd_q <= opnd_val;
      stg_vld <= trig_fire;
      if (trig_fire) begin
        stg_op <= trig_op;
        stg_a  <= first_opnd;
        stg_b  <= trig_val;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_data  <= '0;
      res_flag  <= 1'b0;
      res_valid <= 1'b0;
    end else if (stg_vld) begin
      res_data  <= exec_res;
      res_valid <= 1'b1;
      if (exec_cmp) res_flag <= exec_res[0];
    end
  end

  AST_OPND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !stg_vld |=> ($stable(res_data) && $stable(res_flag))) else $error("AST_OPND_QUIET"); // R1
  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> res_valid) else $error("AST_VALID_STICKY"); // R7
endmodule

// File: rtl/tta_alu_unit.sv
module tta_alu_unit
  import tta_fu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SOCK_W  = 4,
  parameter int NUM_BUS = 2,
  parameter logic [SOCK_W-1:0] OPND_SOCK = 4'd8,
  parameter logic [SOCK_W-1:0] TRIG_BASE = 4'd12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_BUS-1:0]        mv_valid,
  input  logic [NUM_BUS*SOCK_W-1:0] mv_dst,
  input  logic [NUM_BUS*DATA_W-1:0] mv_data,
  output logic [DATA_W-1:0]         res_data,
  output logic                      res_flag,
  output logic                      res_valid
);
  logic              opnd_we;
  logic [DATA_W-1:0] opnd_val;
  logic              trig_fire;
  logic [DATA_W-1:0] trig_val;
  fu_op_e            trig_op;
  logic              stg_vld;
  fu_op_e            stg_op;
  logic [DATA_W-1:0] stg_a;
  logic [DATA_W-1:0] stg_b;
  logic [DATA_W-1:0] exec_res;
  logic              exec_cmp;

  tta_fu_decode #(
    .DATA_W(DATA_W), .SOCK_W(SOCK_W), .NUM_BUS(NUM_BUS),
    .OPND_SOCK(OPND_SOCK), .TRIG_BASE(TRIG_BASE)
  ) u_decode (
    .clk(clk), .rst_n(rst_n),
    .mv_valid(mv_valid), .mv_dst(mv_dst), .mv_data(mv_data),
    .opnd_we(opnd_we), .opnd_val(opnd_val),
    .trig_fire(trig_fire), .trig_val(trig_val), .trig_op(trig_op)
  );

  tta_fu_pipe #(.DATA_W(DATA_W)) u_pipe (
    .clk(clk), .rst_n(rst_n),
    .opnd_we(opnd_we), .opnd_val(opnd_val),
    .trig_fire(trig_fire), .trig_val(trig_val), .trig_op(trig_op),
    .exec_res(exec_res), .exec_cmp(exec_cmp),
    .stg_vld(stg_vld), .stg_op(stg_op), .stg_a(stg_a), .stg_b(stg_b),
    .res_data(res_data), .res_flag(res_flag), .res_valid(res_valid)
  );

  tta_fu_exec #(.DATA_W(DATA_W)) u_exec (
    .op(stg_op), .opa(stg_a), .opb(stg_b),
    .result(exec_res), .is_cmp(exec_cmp)
  );

  AST_FLAG_ADDSUB: assert property (@(posedge clk) disable iff (!rst_n)
    (stg_vld && !stg_op[1]) |=> $stable(res_flag)) else $error("AST_FLAG_ADDSUB"); // R6
  AST_CMP_BOOL: assert property (@(posedge clk) disable iff (!rst_n)
    (stg_vld && stg_op[1]) |=> (res_data[DATA_W-1:1] == '0 && res_data[0] == res_flag))
    else $error("AST_CMP_BOOL"); // R5
  AST_RESULT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    stg_vld |=> res_valid) else $error("AST_RESULT_VALID"); // R3
endmodule

// File: tb/tta_alu_unit_tb.sv
module tta_alu_unit_tb;
  localparam int DW = 32;
  localparam int SW = 4;
  localparam int NB = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NB-1:0]    mv_valid = '0;
  logic [NB*SW-1:0] mv_dst   = '0;
  logic [NB*DW-1:0] mv_data  = '0;
  logic [DW-1:0]    res_data;
  logic             res_flag;
  logic             res_valid;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  string phase = "R10";

  always #4 clk = ~clk;

  tta_alu_unit u_dut (
    .clk(clk), .rst_n(rst_n), .mv_valid(mv_valid), .mv_dst(mv_dst),
    .mv_data(mv_data), .res_data(res_data), .res_flag(res_flag), .res_valid(res_valid)
  );

  // Behavioural reference model
  logic [DW-1:0] m_opnd, m_res, p_a, p_b;
  logic          m_flag, m_rv, p_v;
  int            p_op;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_opnd = 0; m_res = 0; m_flag = 0; m_rv = 0; p_v = 0; p_a = 0; p_b = 0; p_op = 0;
    end else begin
      logic [DW-1:0] nop_val;
      logic          got_t;
      if (p_v) begin
        case (p_op)
          0: m_res = p_a + p_b;
          1: m_res = p_a - p_b;
          2: begin m_res = (p_a == p_b) ? 1 : 0; m_flag = m_res[0]; end
          default: begin m_res = ($signed(p_a) > $signed(p_b)) ? 1 : 0; m_flag = m_res[0]; end
        endcase
        m_rv = 1;
      end
      nop_val = m_opnd;
      for (int b = NB - 1; b >= 0; b--)
        if (mv_valid[b] && mv_dst[b*SW +: SW] == 4'd8) nop_val = mv_data[b*DW +: DW];
      got_t = 0;
      for (int b = 0; b < NB; b++)
        if (!got_t && mv_valid[b] && mv_dst[b*SW +: SW] >= 4'd12) begin
          got_t = 1; p_b = mv_data[b*DW +: DW]; p_op = int'(mv_dst[b*SW +: SW]) - 12;
        end
      p_v = got_t;
      if (got_t) p_a = nop_val;
      m_opnd = nop_val;
    end
  end

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk({phase, " model res_data"}, res_data, m_res);
      chk({phase, " model res_flag"}, {31'd0, res_flag}, {31'd0, m_flag});
      chk({phase, " model res_valid"}, {31'd0, res_valid}, {31'd0, m_rv});
    end
  end

  task automatic put(input int b, input logic [3:0] d, input logic [DW-1:0] v);
    mv_valid[b] = 1'b1;
    mv_dst[b*SW +: SW] = d;
    mv_data[b*DW +: DW] = v;
  endtask

  task automatic tick();
    @(negedge clk);
    mv_valid = '0;
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    chk("R10 res_data", res_data, 0);
    chk("R10 res_flag", {31'd0, res_flag}, 0);
    chk("R10 res_valid", {31'd0, res_valid}, 0);

    // R1 operand write only
    phase = "R1";
    put(0, 4'd8, 32'd5); tick(); tick(); tick();
    chk("R1 no result", res_data, 0);
    chk("R1 no valid", {31'd0, res_valid}, 0);

    // R2/R3/R4 add
    phase = "R4";
    put(0, 4'd12, 32'd7); tick();
    chk("R3 not yet", {31'd0, res_valid}, 0);
    tick();
    chk("R2 add 5+7", res_data, 32'd12);
    chk("R3 valid", {31'd0, res_valid}, 1);

    // sub
    put(1, 4'd13, 32'd9); tick(); tick();
    chk("R4 sub 5-9", res_data, 32'hFFFF_FFFC);
    chk("R6 flag after sub", {31'd0, res_flag}, 0);

    // R8 same-cycle operand + eq trigger
    phase = "R8";
    put(0, 4'd8, 32'd9); put(1, 4'd14, 32'd9); tick(); tick();
    chk("R8 eq with new operand", res_data, 32'd1);
    chk("R5 flag eq", {31'd0, res_flag}, 1);

    // R6 add leaves flag
    phase = "R6";
    put(0, 4'd12, 32'd1); tick(); tick();
    chk("R6 add 9+1", res_data, 32'd10);
    chk("R6 flag kept", {31'd0, res_flag}, 1);

    // signed gt
    phase = "R5";
    put(0, 4'd8, 32'hFFFF_FFFF); put(1, 4'd15, 32'd1); tick(); tick();
    chk("R4 gt -1>1", res_data, 0);
    chk("R5 flag gt false", {31'd0, res_flag}, 0);
    put(1, 4'd8, 32'd3); put(0, 4'd15, 32'hFFFF_FFFE); tick(); tick();
    chk("R4 gt 3>-2", res_data, 32'd1);
    chk("R5 flag gt true", {31'd0, res_flag}, 1);

    // R7 hold
    phase = "R7";
    repeat (5) tick();
    chk("R7 held res", res_data, 32'd1);
    chk("R7 held valid", {31'd0, res_valid}, 1);

    // R9 foreign sockets
    phase = "R9";
    put(0, 4'd3, 32'd77); put(1, 4'd9, 32'd55); tick();
    put(0, 4'd0, 32'd1); put(1, 4'd11, 32'd2); tick(); tick();
    chk("R9 res untouched", res_data, 32'd1);
    put(0, 4'd12, 32'd0); tick(); tick();
    chk("R9 operand untouched", res_data, 32'd3);

    // wrap add
    phase = "R4";
    put(0, 4'd8, 32'hFFFF_FFFF); put(1, 4'd12, 32'd1); tick(); tick();
    chk("R4 add wraps", res_data, 0);

    // R11 back-to-back
    phase = "R11";
    put(0, 4'd8, 32'd100); tick();
    put(0, 4'd12, 32'd1); tick();
    put(0, 4'd12, 32'd2); tick();
    chk("R11 first", res_data, 32'd101);
    put(0, 4'd13, 32'd3); tick();
    chk("R11 second", res_data, 32'd102);
    tick();
    chk("R11 third", res_data, 32'd97);

    // Random traffic against the model
    phase = "R4";
    for (int n = 0; n < 400; n++) begin
      logic [3:0] d0, d1;
      d0 = 4'($urandom_range(0, 15));
      d1 = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 3) != 0) put(0, d0, ($urandom_range(0, 1) != 0) ? 32'($urandom_range(0, 7)) : $urandom());
      if ($urandom_range(0, 2) != 0 && !((d0 == 4'd8 && d1 == 4'd8) || (d0 >= 4'd12 && d1 >= 4'd12)))
        put(1, d1, ($urandom_range(0, 1) != 0) ? 32'($urandom_range(0, 7)) : $urandom());
      tick();
    end
    tick(); tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule